// File: doc/BRIEF.md
# CAN Receive Byte Ring

This block holds received CAN frames in a circular byte store as records of varying length. Each record begins with a header byte that describes it, so nothing but the bytes themselves is kept per record. A frame offered on the input side is packed into its record form and written into the ring one byte per clock. Software-side logic reads the oldest record through a 13-byte window and drops it with a release strobe.

On a release, the block reads the header at the read pointer and works out how far the pointer moves. If a new record does not fit in the free space, it is dropped whole and an overrun pulse is raised. Error frames are never stored. In standard-only operation, extended frames are never stored either.

The controller is a three-state machine:
- **HALT** is the reset mode. It ignores frames and releases.
- **IDLE** waits for a frame.
- **FILL** writes the captured record byte by byte.

The transitions are:
- **resume** (HALT to IDLE, when `halt_mode` falls) clears the counts and both pointers.
- **suspend** (IDLE or FILL to HALT, when `halt_mode` rises) abandons any record that is half written.
- **capture** (IDLE to FILL) takes in a frame that is accepted and fits.
- **finish** (FILL to IDLE) happens on the last byte and commits the record.

Top module: `canrx_ring`

## Requirements
- R1: Record byte 0 is the header: bit 7 = extended flag, bit 6 = remote flag, bits 5:4 = 0, bits 3:0 = the DLC exactly as received.
- R2: An extended record holds ID[28:21] in byte 1, ID[20:13] in byte 2, ID[12:5] in byte 3 and {ID[4:0],3'b000} in byte 4, with data from byte 5.
- R3: A standard record holds ID[10:3] in byte 1 and {ID[2:0],5'b00000} in byte 2, with data from byte 3.
- R4: Record length = 3, plus 2 for extended, plus min(DLC,8) data bytes for a data frame. A remote frame stores no data bytes.
- R5: If used + length exceeds the 64-byte capacity, the frame is dropped whole. `overrun` is then high for exactly one cycle, in the cycle after the frame is offered, and the counts and contents stay unchanged. `used_bytes` never exceeds 64.
- R6: For `win_addr` k in 0..12, `win_data` is the byte at (read pointer + k) mod 64. Addresses 13..15 read 0.
- R7: A release with no stored message has no effect. Otherwise it advances the read pointer by the head record's length (mod 64), subtracts that length from `used_bytes` and decrements `msg_count`. `msg_count` is 0 exactly when `used_bytes` is 0.
- R8: An error frame, or an extended frame while `std_only` is 1, is dropped without overrun and without any change.
- R9: While in HALT, frames and releases are ignored and the counts hold. Leaving HALT clears both counts and both pointers.
- R10: A stored record is written over `len` cycles after capture, with `wr_busy` high throughout. The counts change only on the last cycle, and `msg_count` grows by at most one per cycle.
- R11: A release in the same cycle as a record's final write is honoured, and both count updates take effect.
- R12: After reset: `msg_count`=0, `used_bytes`=0, `pending`=0, `overrun`=0, `wr_busy`=0. `pending` is 1 whenever `msg_count` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_mode | input | 1 | Reset (halt) mode of the controller |
| std_only | input | 1 | Reject extended frames when 1 |
| fr_valid | input | 1 | A frame is offered this cycle (taken only when idle) |
| fr_id | input | 29 | Identifier (standard IDs in bits 10:0) |
| fr_ext | input | 1 | Extended-frame flag |
| fr_rtr | input | 1 | Remote-request flag |
| fr_err | input | 1 | Error-frame flag |
| fr_dlc | input | 4 | Data length code |
| fr_data | input | 64 | Data bytes, byte i in bits 8i+7:8i |
| rel | input | 1 | Release the oldest record |
| win_addr | input | 4 | Read window offset |
| win_data | output | 8 | Read window byte |
| msg_count | output | 7 | Stored record count |
| used_bytes | output | 7 | Stored byte count |
| pending | output | 1 | At least one record stored |
| overrun | output | 1 | One-cycle drop-on-full pulse |
| wr_busy | output | 1 | A record is being written |

## Verification
The hardest situation to reach is a release that lands on exactly the edge where a record commits, with the ring close to full and the pointers wrapping. The stimulus counts the record length from the capture edge and raises the release for the final write cycle only. Beforehand it fills the ring to exactly 64 bytes from a read pointer away from zero, so that the records straddle the wrap. Seeded random frames, with DLC values above 8, remote frames and error frames mixed in, then exercise the header-driven release against a byte-level model of the ring.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    localparam int REC_MAX = 13;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_IDLE,
        ST_FILL
    } fill_st_e;

    // Record length implied by a header byte (R4)
    function automatic logic [3:0] rec_len_of(input logic [7:0] hdr);
        logic [3:0] n;
        n = (hdr[3:0] > 4'd8) ? 4'd8 : hdr[3:0];
        if (hdr[6]) begin
            n = 4'd0;
        end
        return 4'd3 + (hdr[7] ? 4'd2 : 4'd0) + n;
    endfunction

endpackage

// File: rtl/canrx_rec_pack.sv
module canrx_rec_pack
    import canrx_pkg::*;
(
    input  logic [28:0]              fr_id,
    input  logic                     fr_ext,
    input  logic                     fr_rtr,
    input  logic [3:0]               fr_dlc,
    input  logic [63:0]              fr_data,
    output logic [REC_MAX-1:0][7:0]  rec_bytes,
    output logic [3:0]               rec_len
);

    logic [7:0] hdr;
    logic [3:0] ndata;
    int         base;

    always_comb begin
        hdr   = {fr_ext, fr_rtr, 2'b00, fr_dlc};
        ndata = (fr_dlc > 4'd8) ? 4'd8 : fr_dlc;
        if (fr_rtr) begin
            ndata = 4'd0;
        end
        rec_bytes    = '0;
        rec_bytes[0] = hdr;
        if (fr_ext) begin
            rec_bytes[1] = fr_id[28:21];
            rec_bytes[2] = fr_id[20:13];
            rec_bytes[3] = fr_id[12:5];
            rec_bytes[4] = {fr_id[4:0], 3'b000};
            base = 5;
        end else begin
            rec_bytes[1] = fr_id[10:3];
            rec_bytes[2] = {fr_id[2:0], 5'b00000};
            base = 3;
        end
        for (int i = 0; i < 8; i++) begin
            if (i < int'(ndata)) begin
                rec_bytes[base + i] = fr_data[8*i +: 8];
            end
        end
    end

    assign rec_len = rec_len_of(hdr);

endmodule

// File: rtl/canrx_ring_mem.sv
module canrx_ring_mem #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rda_addr,
    output logic [7:0]    rda_data,
    input  logic [AW-1:0] rdb_addr,
    output logic [7:0]    rdb_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rda_data = mem[rda_addr];
    assign rdb_data = mem[rdb_addr];

endmodule

// File: rtl/canrx_window.sv
module canrx_window
    import canrx_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0] head,
    input  logic [3:0]    win_addr,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic [7:0]    win_data
);

    logic in_range;

    assign in_range = int'(win_addr) < REC_MAX;
    assign rd_addr  = head + AW'(win_addr);
    assign win_data = in_range ? rd_data : 8'h00;

endmodule

// File: rtl/canrx_ring.sv
module canrx_ring
    import canrx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_mode,
    input  logic          std_only,
    input  logic          fr_valid,
    input  logic [28:0]   fr_id,
    input  logic          fr_ext,
    input  logic          fr_rtr,
    input  logic          fr_err,
    input  logic [3:0]    fr_dlc,
    input  logic [63:0]   fr_data,
    input  logic          rel,
    input  logic [3:0]    win_addr,
    output logic [7:0]    win_data,
    output logic [CW-1:0] msg_count,
    output logic [CW-1:0] used_bytes,
    output logic          pending,
    output logic          overrun,
    output logic          wr_busy
);

    fill_st_e state_q, state_d;

    logic [AW-1:0] head_q, tail_q;
    logic [CW-1:0] used_q, msgs_q;
    logic [REC_MAX-1:0][7:0] rec_q;
    logic [3:0] len_q, idx_q;
    logic ovr_q;

    logic [REC_MAX-1:0][7:0] pk_bytes;
    logic [3:0] pk_len;
    logic [CW:0] need_total;
    logic kind_ok, fits, take, reject_full, commit, do_rel, resume;
    logic [AW-1:0] win_rd_addr;
    logic [7:0] win_rd_data, head_hdr;
    logic [3:0] rel_len;
    logic wr_en;
    logic [AW-1:0] wr_addr;

    canrx_rec_pack u_pack (
        .fr_id    (fr_id),
        .fr_ext   (fr_ext),
        .fr_rtr   (fr_rtr),
        .fr_dlc   (fr_dlc),
        .fr_data  (fr_data),
        .rec_bytes(pk_bytes),
        .rec_len  (pk_len)
    );

    canrx_ring_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (rec_q[idx_q]),
        .rda_addr(win_rd_addr),
        .rda_data(win_rd_data),
        .rdb_addr(head_q),
        .rdb_data(head_hdr)
    );

    canrx_window #(.AW(AW)) u_win (
        .head    (head_q),
        .win_addr(win_addr),
        .rd_addr (win_rd_addr),
        .rd_data (win_rd_data),
        .win_data(win_data)
    );

    // Acceptance and event decode
    assign kind_ok     = !fr_err && !(std_only && fr_ext);
    assign need_total  = {1'b0, used_q} + (CW+1)'(pk_len);
    assign fits        = need_total <= (CW+1)'(DEPTH);
    assign take        = (state_q == ST_IDLE) && !halt_mode && fr_valid && kind_ok && fits;
    assign reject_full = (state_q == ST_IDLE) && !halt_mode && fr_valid && kind_ok && !fits;
    assign commit      = (state_q == ST_FILL) && !halt_mode && (idx_q == len_q - 4'd1);
    assign rel_len     = rec_len_of(head_hdr);
    assign do_rel      = rel && (msgs_q != '0) && (state_q != ST_HALT) && !halt_mode;
    assign resume      = (state_q == ST_HALT) && !halt_mode;
    assign wr_en       = (state_q == ST_FILL) && !halt_mode;
    assign wr_addr     = tail_q + AW'(idx_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (!halt_mode) state_d = ST_IDLE;
            ST_IDLE: begin
                if (halt_mode) state_d = ST_HALT;
                else if (take) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (halt_mode) state_d = ST_HALT;
                else if (commit) state_d = ST_IDLE;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // Record capture and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
            len_q <= 4'd0;
            idx_q <= 4'd0;
        end else if (take) begin
            rec_q <= pk_bytes;
            len_q <= pk_len;
            idx_q <= 4'd0;
        end else if (wr_en) begin
            idx_q <= idx_q + 4'd1;
        end
    end

    // Pointers and counts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            used_q <= '0;
            msgs_q <= '0;
        end else if (resume) begin
            head_q <= '0;
            tail_q <= '0;
            used_q <= '0;
            msgs_q <= '0;
        end else begin
            if (commit) tail_q <= tail_q + AW'(len_q);
            if (do_rel) head_q <= head_q + AW'(rel_len);
            used_q <= used_q + (commit ? CW'(len_q) : '0) - (do_rel ? CW'(rel_len) : '0);
            msgs_q <= msgs_q + CW'(commit) - CW'(do_rel);
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= reject_full;
        end
    end

    assign overrun    = ovr_q;
    assign wr_busy    = (state_q == ST_FILL);
    assign msg_count  = msgs_q;
    assign used_bytes = used_q;
    assign pending    = (msgs_q != '0);

endmodule

// File: rtl/canrx_ring_chk.sv
module canrx_ring_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt_mode,
    input logic          rel,
    input logic          wr_busy,
    input logic          overrun,
    input logic [CW-1:0] msg_count,
    input logic [CW-1:0] used_bytes
);

    assert_used_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(used_bytes) <= DEPTH);

    assert_overrun_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !wr_busy);

    assert_empty_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_count == '0) == (used_bytes == '0));

    assert_empty_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && msg_count == '0 && !wr_busy) |=> (msg_count == '0 && used_bytes == '0));

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt_mode) |-> ($stable(msg_count) && $stable(used_bytes)));

    assert_grow_on_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (used_bytes > $past(used_bytes)) |-> $past(wr_busy));

    assert_msg_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(msg_count) <= int'($past(msg_count)) + 1);

endmodule

bind canrx_ring canrx_ring_chk #(.DEPTH(DEPTH)) u_canrx_ring_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_mode (halt_mode),
    .rel       (rel),
    .wr_busy   (wr_busy),
    .overrun   (overrun),
    .msg_count (msg_count),
    .used_bytes(used_bytes)
);

// File: tb/canrx_ring_bench.sv
`timescale 1ns/100ps
module canrx_ring_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_mode = 1'b1;
    logic        std_only = 1'b0;
    logic        fr_valid = 1'b0;
    logic [28:0] fr_id = '0;
    logic        fr_ext = 1'b0, fr_rtr = 1'b0, fr_err = 1'b0;
    logic [3:0]  fr_dlc = '0;
    logic [63:0] fr_data = '0;
    logic        rel = 1'b0;
    logic [3:0]  win_addr = '0;
    logic [7:0]  win_data;
    logic [6:0]  msg_count, used_bytes;
    logic        pending, overrun, wr_busy;

    int total = 0;
    int bad = 0;

    logic [7:0] mir [64];
    int m_head = 0, m_tail = 0, m_used = 0, m_msgs = 0;

    always #2.5 clk = ~clk;

    canrx_ring u_canrx_ring (
        .clk(clk), .rst_n(rst_n), .halt_mode(halt_mode), .std_only(std_only),
        .fr_valid(fr_valid), .fr_id(fr_id), .fr_ext(fr_ext), .fr_rtr(fr_rtr),
        .fr_err(fr_err), .fr_dlc(fr_dlc), .fr_data(fr_data), .rel(rel),
        .win_addr(win_addr), .win_data(win_data), .msg_count(msg_count),
        .used_bytes(used_bytes), .pending(pending), .overrun(overrun), .wr_busy(wr_busy)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete act=1 exp=0");
        summary();
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    function automatic int len_from_hdr(input logic [7:0] h);
        int n;
        n = (h[3:0] > 8) ? 8 : int'(h[3:0]);
        if (h[6]) n = 0;
        return 3 + (h[7] ? 2 : 0) + n;
    endfunction

    function automatic int mk_rec(input logic [28:0] id, input logic ext, input logic rtr,
                                  input logic [3:0] dlc, input logic [63:0] data,
                                  output logic [7:0] b [13]);
        int n, base;
        for (int i = 0; i < 13; i++) b[i] = 8'h00;
        b[0] = {ext, rtr, 2'b00, dlc};
        if (ext) begin
            b[1] = id[28:21]; b[2] = id[20:13]; b[3] = id[12:5]; b[4] = {id[4:0], 3'b000};
            base = 5;
        end else begin
            b[1] = id[10:3]; b[2] = {id[2:0], 5'b00000};
            base = 3;
        end
        n = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
        for (int i = 0; i < n; i++) b[base + i] = data[8*i +: 8];
        return base + n;
    endfunction

    task automatic pop();
        int l;
        l = len_from_hdr(mir[m_head]);
        m_head = (m_head + l) % 64;
        m_used -= l;
        m_msgs--;
    endtask

    task automatic check_all(input string tag);
        chk(msg_count == 7'(m_msgs), {tag, " R7 msg_count"}, int'(msg_count), m_msgs);
        chk(used_bytes == 7'(m_used), {tag, " R7 used_bytes"}, int'(used_bytes), m_used);
        chk(pending == (m_msgs != 0), {tag, " R12 pending"}, int'(pending), int'(m_msgs != 0));
        chk(wr_busy == 1'b0, {tag, " R10 idle after store"}, int'(wr_busy), 0);
        for (int k = 0; k < 13; k++) begin
            if (k < m_used) begin
                win_addr = 4'(k);
                #0.1;
                chk(win_data == mir[(m_head + k) % 64], {tag, " R6 window byte"},
                    int'(win_data), int'(mir[(m_head + k) % 64]));
            end
        end
    endtask

    task automatic send(input logic [28:0] id, input logic ext, input logic rtr, input logic err,
                        input logic [3:0] dlc, input logic [63:0] data, input bit with_rel,
                        input string tag);
        logic [7:0] b [13];
        int len;
        bit drop, full;
        len  = mk_rec(id, ext, rtr, dlc, data, b);
        drop = halt_mode || err || (std_only && ext);
        full = !drop && (m_used + len > 64);
        @(negedge clk);
        fr_id = id; fr_ext = ext; fr_rtr = rtr; fr_err = err; fr_dlc = dlc; fr_data = data;
        fr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fr_valid = 1'b0;
        if (drop || full) begin
            chk(overrun == full, {tag, " R5/R8 overrun on drop"}, int'(overrun), int'(full));
            if (full) begin
                @(negedge clk);
                chk(overrun == 1'b0, {tag, " R5 overrun one cycle"}, int'(overrun), 0);
            end
            check_all(tag);
            return;
        end
        chk(overrun == 1'b0, {tag, " R5 no overrun when fits"}, int'(overrun), 0);
        chk(wr_busy == 1'b1, {tag, " R10 busy during store"}, int'(wr_busy), 1);
        chk(msg_count == 7'(m_msgs), {tag, " R10 count held mid-store"}, int'(msg_count), m_msgs);
        for (int k = 0; k < len; k++) mir[(m_tail + k) % 64] = b[k];
        repeat (len - 1) @(posedge clk);
        if (with_rel) begin
            @(negedge clk);
            rel = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        rel = 1'b0;
        if (with_rel && m_msgs > 0) pop();
        m_tail = (m_tail + len) % 64;
        m_used += len;
        m_msgs++;
        check_all(tag);
    endtask

    task automatic release_one(input string tag);
        @(negedge clk);
        rel = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rel = 1'b0;
        if (!halt_mode && m_msgs > 0) pop();
        check_all(tag);
    endtask

    task automatic win_is(input int a, input int exp, input string what);
        win_addr = 4'(a);
        #0.1;
        chk(win_data == 8'(exp), what, int'(win_data), exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(msg_count == 0, "R12 reset msg_count", int'(msg_count), 0);
        chk(used_bytes == 0, "R12 reset used_bytes", int'(used_bytes), 0);
        chk(pending == 0, "R12 reset pending", int'(pending), 0);
        chk(overrun == 0, "R12 reset overrun", int'(overrun), 0);
        chk(wr_busy == 0, "R12 reset wr_busy", int'(wr_busy), 0);

        halt_mode = 1'b0;
        @(posedge clk);
        @(negedge clk);

        release_one("empty release R7");

        // R1, R3: standard record layout
        send(29'h5A3, 0, 0, 0, 4'd2, 64'h2211, 0, "std frame");
        win_is(0, 8'h02, "R1 std header");
        win_is(1, 8'hB4, "R3 std id high");
        win_is(2, 8'h60, "R3 std id low");
        win_is(3, 8'h11, "R3 std data0");
        win_is(4, 8'h22, "R3 std data1");
        // R2: extended record layout
        send(29'h12345678, 1, 0, 0, 4'd1, 64'h77, 0, "ext frame");
        win_is(5, 8'h81, "R1 ext header");
        win_is(6, 8'h91, "R2 ext id 28:21");
        win_is(7, 8'hA2, "R2 ext id 20:13");
        win_is(8, 8'hB3, "R2 ext id 12:5");
        win_is(9, 8'hC0, "R2 ext id 4:0");
        win_is(10, 8'h77, "R2 ext data0");
        // R6: out-of-window addresses
        win_is(13, 0, "R6 addr 13 reads 0");
        win_is(15, 0, "R6 addr 15 reads 0");
        // R4: remote and oversize DLC
        send(29'h123, 0, 1, 0, 4'd5, 64'hFFFF_FFFF, 0, "remote");
        chk(used_bytes == 7'd14, "R4 remote stores 3 bytes", int'(used_bytes), 14);
        send(29'h07F, 0, 0, 0, 4'd12, 64'h8877665544332211, 0, "dlc12");
        chk(used_bytes == 7'd25, "R4 dlc above 8 stores 8 data", int'(used_bytes), 25);
        // R8: rejected kinds
        send(29'h001, 0, 0, 1, 4'd3, 64'h1, 0, "R8 error frame");
        std_only = 1'b1;
        send(29'h00ABCDE, 1, 0, 0, 4'd2, 64'h1, 0, "R8 ext in std-only");
        std_only = 1'b0;
        // drain plus one extra release
        repeat (5) release_one("drain R7");

        // R5: fill exactly to capacity across the wrap
        repeat (4) send(29'h1ABCDEF, 1, 0, 0, 4'd8, 64'h0102030405060708, 0, "fill ext8");
        send(29'h0055AA, 1, 0, 0, 4'd7, 64'h00A0B0C0D0E0F011, 0, "fill ext7");
        chk(used_bytes == 7'd64, "R5 exact fit accepted", int'(used_bytes), 64);
        send(29'h3, 0, 1, 0, 4'd0, 64'h0, 0, "R5 full overrun");
        release_one("R7 after full");
        // R11: release on the commit edge
        send(29'h0F0F0F0, 1, 0, 0, 4'd8, 64'hDEADBEEFCAFEF00D, 1, "R11 release at commit");

        // R9: halt ignores frames and releases; leaving clears
        halt_mode = 1'b1;
        @(posedge clk);
        @(negedge clk);
        send(29'h111, 0, 0, 0, 4'd1, 64'h5, 0, "R9 frame in halt");
        release_one("R9 release in halt");
        @(negedge clk);
        halt_mode = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_head = 0; m_tail = 0; m_used = 0; m_msgs = 0;
        chk(msg_count == 0, "R9 leave halt clears msg_count", int'(msg_count), 0);
        chk(used_bytes == 0, "R9 leave halt clears used_bytes", int'(used_bytes), 0);

        // Seeded random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 99));
            if (op < 60) begin
                std_only = ($urandom_range(0, 7) == 0);
                send(29'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0),
                     ($urandom_range(0, 15) == 0), 4'($urandom),
                     {$urandom, $urandom}, 0, "random store");
            end else if (op < 92) begin
                release_one("random release");
            end else begin
                std_only = 1'b0;
                send(29'($urandom), 1'($urandom), 1'b0, 1'b0, 4'($urandom),
                     {$urandom, $urandom}, 1, "random R11");
            end
        end
        std_only = 1'b0;
        summary();
    end

endmodule